// File: doc/BRIEF.md
# Queued Note Tone Player

This block sits behind a serial byte receiver. It takes note codes as they arrive, holds them in a bounded queue and plays them in order, one at a time, as square-wave tones on a single buzzer pin. The receiver may deliver a new byte in any cycle, including bursts of bytes in consecutive cycles and bytes that arrive while a note is sounding. Reception never waits for playback.

Each played note occupies one fixed-length time slot. When a note is taken from the queue, its code also enters the right-hand end of a six-digit history word, and the older digits move one place to the left. A separate seven-segment scanner displays this word. The block also reports how many notes are waiting and whether it has any work left.

Top module: `note_queue_player`

## Requirements
- R1: Note codes 1 to 8 select the pitches 262, 294, 330, 349, 392, 440, 494 and 523 Hz. While a note plays, each high or low phase of the buzzer lasts CLK_HZ/(2·pitch) clock cycles, using integer division.
- R2: Each note plays for SLOT_CYCLES cycles. When the queue still holds notes, consecutive notes start exactly SLOT_CYCLES+2 cycles apart. The two extra cycles are the queue read and the load.
- R3: A byte whose full 8-bit value is outside 1..8 is discarded. It changes neither the queue level, the history, the buzzer nor the busy flag. For example, 0x81 is discarded even though its low nibble is 1.
- R4: A valid note byte is stored only while the queue level is below QUEUE_LIMIT (100); otherwise it is dropped. The level never exceeds QUEUE_LIMIT.
- R5: A note is taken from the queue only when the queue is non-empty and no note is loading or playing. Notes are played in the order they were accepted.
- R6: When a note starts, the history word shifts left by one 4-bit digit and the note code enters bits [3:0]. The leftmost digit is discarded.
- R7: After reset, every history digit is 4'hE, the queue level is 0, and the buzzer and busy flag are low. Whenever no note is playing, the buzzer is driven low.
- R8: A write and a read in the same cycle both complete and leave the queue level unchanged.
- R9: Bytes that arrive while a note plays are queued without disturbing it. The busy flag is high while a note is loading or playing, or while the queue is non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| byte_valid_i | input | 1 | One-cycle strobe marking a received byte |
| byte_i | input | 8 | Received byte |
| buzzer_o | output | 1 | Square-wave tone output |
| history_o | output | 4*DIGITS | Packed digit history, newest digit in bits [3:0] |
| queue_level_o | output | $clog2(QUEUE_DEPTH+1) | Number of notes waiting in the queue |
| busy_o | output | 1 | High while a note plays or notes are waiting |

## Verification
Some properties are checked on every cycle. These are: the queue level staying within its limit, no write into a full queue and no read from an empty one, reads gated off while a slot is active, an unchanged level on a combined read and write, the digit shift on each note start with the history held between starts, and a silent buzzer outside a slot. Other behaviours need the bench scenarios. These are the pitch of each tone, the slot spacing across a long back-to-back run, playback order through the queue, the exact point where a burst starts to be dropped, and the rejection of out-of-range byte values.

// File: rtl/nqp_pkg.sv
package nqp_pkg;

    localparam int          NOTE_W     = 4;
    localparam logic [3:0]  BLANK_CODE = 4'hE;
    localparam int unsigned LOWEST_HZ  = 262;

    typedef logic [NOTE_W-1:0] note_code_t;

    typedef struct packed {
        logic       valid;
        note_code_t code;
    } note_evt_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_LOAD,
        SEQ_PLAY
    } seq_state_t;

    function automatic logic is_note(input logic [7:0] b);
        return (b >= 8'd1) && (b <= 8'd8);
    endfunction

    function automatic int unsigned pitch_hz(input note_code_t c);
        case (c)
            4'd1:    return 262;
            4'd2:    return 294;
            4'd3:    return 330;
            4'd4:    return 349;
            4'd5:    return 392;
            4'd6:    return 440;
            4'd7:    return 494;
            4'd8:    return 523;
            default: return LOWEST_HZ;
        endcase
    endfunction

    function automatic int unsigned half_period(input note_code_t c, input int unsigned clk_hz);
        return clk_hz / (2 * pitch_hz(c));
    endfunction

endpackage

// File: rtl/note_fifo.sv
module note_fifo #(
    parameter int DEPTH = 128,
    parameter int W     = 4,
    parameter int CNT_W = 8
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         rd_en_i,
    output logic [W-1:0] rd_data_o,
    output logic [CNT_W-1:0] count_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] count_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty_o = (count_q == '0);
    assign full_o  = (count_q == CNT_W'(DEPTH));
    assign count_o = count_q;

    always_ff @(posedge clk_i) begin
        if (wr_en_i) mem_q[wr_ptr_q] <= wr_data_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wr_ptr_q  <= '0;
            rd_ptr_q  <= '0;
            count_q   <= '0;
            rd_data_o <= '0;
        end else begin
            if (wr_en_i) wr_ptr_q <= bump(wr_ptr_q);
            if (rd_en_i) begin
                rd_ptr_q  <= bump(rd_ptr_q);
                rd_data_o <= mem_q[rd_ptr_q];
            end
            case ({wr_en_i, rd_en_i})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_en_i |-> !full_o); // R4
    AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_en_i |-> !empty_o); // R5
    AST_SAME_CYCLE_LEVEL: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && rd_en_i) |=> (count_o == $past(count_o))); // R8

endmodule

// File: rtl/note_slot_ctrl.sv
module note_slot_ctrl import nqp_pkg::*; #(
    parameter int SLOT_CYCLES = 25_000_000
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       q_empty_i,
    input  note_code_t q_data_i,
    output logic       rd_en_o,
    output note_evt_t  start_o,
    output logic       active_o,
    output note_code_t cur_note_o,
    output logic       idle_o
);
    localparam int SLOT_W = (SLOT_CYCLES > 2) ? $clog2(SLOT_CYCLES) : 1;

    seq_state_t       state_q;
    logic [SLOT_W-1:0] slot_cnt_q;
    logic             slot_last;

    assign slot_last  = (slot_cnt_q == SLOT_W'(SLOT_CYCLES - 1));
    assign rd_en_o    = (state_q == SEQ_IDLE) && !q_empty_i;
    assign active_o   = (state_q == SEQ_PLAY);
    assign idle_o     = (state_q == SEQ_IDLE);
    assign start_o.valid = (state_q == SEQ_LOAD);
    assign start_o.code  = q_data_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q    <= SEQ_IDLE;
            slot_cnt_q <= '0;
            cur_note_o <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: if (!q_empty_i) state_q <= SEQ_LOAD;
                SEQ_LOAD: begin
                    state_q    <= SEQ_PLAY;
                    slot_cnt_q <= '0;
                    cur_note_o <= q_data_i;
                end
                SEQ_PLAY: begin
                    if (slot_last) begin
                        state_q    <= SEQ_IDLE;
                        slot_cnt_q <= '0;
                    end else begin
                        slot_cnt_q <= slot_cnt_q + 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    AST_READ_GATED: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_en_o |-> (!q_empty_i && !active_o && !start_o.valid)); // R5
    AST_START_PLAYS: assert property (@(posedge clk_i) disable iff (rst_i)
        start_o.valid |=> (active_o && !rd_en_o)); // R2

endmodule

// File: rtl/tone_gen.sv
module tone_gen import nqp_pkg::*; #(
    parameter int unsigned CLK_HZ = 50_000_000
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       active_i,
    input  note_code_t note_i,
    output logic       buzz_o
);
    localparam int unsigned MAX_HALF = CLK_HZ / (2 * LOWEST_HZ);
    localparam int DIV_W = (MAX_HALF > 1) ? $clog2(MAX_HALF + 1) : 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] half_w;

    assign half_w = DIV_W'(half_period(note_i, CLK_HZ));

    always_ff @(posedge clk_i) begin
        if (rst_i || !active_i) begin
            div_q  <= '0;
            buzz_o <= 1'b0;
        end else if (div_q == half_w - DIV_W'(1)) begin
            div_q  <= '0;
            buzz_o <= ~buzz_o;
        end else begin
            div_q  <= div_q + 1'b1;
        end
    end

    AST_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        !active_i |=> !buzz_o); // R7

endmodule

// File: rtl/digit_history.sv
module digit_history import nqp_pkg::*; #(
    parameter int DIGITS = 6
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  note_evt_t             evt_i,
    output logic [NOTE_W*DIGITS-1:0] hist_o
);
    localparam int HW = NOTE_W * DIGITS;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hist_o <= {DIGITS{BLANK_CODE}};
        end else if (evt_i.valid) begin
            hist_o <= {hist_o[HW-NOTE_W-1:0], evt_i.code};
        end
    end

    AST_HIST_SHIFT: assert property (@(posedge clk_i) disable iff (rst_i)
        evt_i.valid |=> ((hist_o[HW-1:NOTE_W] == $past(hist_o[HW-NOTE_W-1:0]))
                         && (hist_o[NOTE_W-1:0] == $past(evt_i.code)))); // R6
    AST_HIST_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !evt_i.valid |=> $stable(hist_o)); // R3

endmodule

// File: rtl/note_queue_player.sv
module note_queue_player import nqp_pkg::*; #(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int          SLOT_CYCLES = 25_000_000,
    parameter int          QUEUE_DEPTH = 128,
    parameter int          QUEUE_LIMIT = 100,
    parameter int          DIGITS      = 6
) (
    input  logic                               clk_i,
    input  logic                               rst_i,
    input  logic                               byte_valid_i,
    input  logic [7:0]                         byte_i,
    output logic                               buzzer_o,
    output logic [4*DIGITS-1:0]                history_o,
    output logic [$clog2(QUEUE_DEPTH+1)-1:0]   queue_level_o,
    output logic                               busy_o
);
    localparam int CNT_W = $clog2(QUEUE_DEPTH + 1);

    logic       wr_en, rd_en, q_empty, q_full, seq_idle, active;
    note_code_t rd_data, cur_note;
    note_evt_t  start_evt;
    logic [CNT_W-1:0] level;

    assign wr_en = byte_valid_i && is_note(byte_i) && !q_full
                   && (level < CNT_W'(QUEUE_LIMIT));

    note_fifo #(.DEPTH(QUEUE_DEPTH), .W(NOTE_W), .CNT_W(CNT_W)) u_fifo (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (wr_en),
        .wr_data_i (byte_i[NOTE_W-1:0]),
        .rd_en_i   (rd_en),
        .rd_data_o (rd_data),
        .count_o   (level),
        .empty_o   (q_empty),
        .full_o    (q_full)
    );

    note_slot_ctrl #(.SLOT_CYCLES(SLOT_CYCLES)) u_slot (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .q_empty_i  (q_empty),
        .q_data_i   (rd_data),
        .rd_en_o    (rd_en),
        .start_o    (start_evt),
        .active_o   (active),
        .cur_note_o (cur_note),
        .idle_o     (seq_idle)
    );

    tone_gen #(.CLK_HZ(CLK_HZ)) u_tone (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .active_i (active),
        .note_i   (cur_note),
        .buzz_o   (buzzer_o)
    );

    digit_history #(.DIGITS(DIGITS)) u_hist (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .evt_i  (start_evt),
        .hist_o (history_o)
    );

    assign queue_level_o = level;
    assign busy_o        = !seq_idle || !q_empty;

    AST_LEVEL_CAP: assert property (@(posedge clk_i) disable iff (rst_i)
        queue_level_o <= CNT_W'(QUEUE_LIMIT)); // R4
    AST_BUSY_WHILE_PLAYING: assert property (@(posedge clk_i) disable iff (rst_i)
        active |-> busy_o); // R9

endmodule

// File: tb/note_queue_player_test.sv
module note_queue_player_test;
    localparam int unsigned CLK_HZ = 52_300;
    localparam int SLOT  = 400;
    localparam int DEPTH = 128;
    localparam int LIMIT = 100;
    localparam int DIG   = 6;
    localparam int LIMIT_CYC = 190_000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [7:0] in_byte = 8'd0;
    logic buz, busy;
    logic [4*DIG-1:0] hist;
    logic [7:0] level;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int exp_q[$];
    logic [4*DIG-1:0] model_hist = {DIG{4'hE}};
    bit gap_on = 0;
    bit have_last = 0;
    int last_t = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    note_queue_player #(.CLK_HZ(CLK_HZ), .SLOT_CYCLES(SLOT), .QUEUE_DEPTH(DEPTH),
                        .QUEUE_LIMIT(LIMIT), .DIGITS(DIG)) uut (
        .clk_i(clk), .rst_i(rst), .byte_valid_i(in_valid), .byte_i(in_byte),
        .buzzer_o(buz), .history_o(hist), .queue_level_o(level), .busy_o(busy));

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int exp_half(input int code);
        int f;
        case (code)
            1: f = 262; 2: f = 294; 3: f = 330; 4: f = 349;
            5: f = 392; 6: f = 440; 7: f = 494; default: f = 523;
        endcase
        return int'(CLK_HZ) / (2 * f);
    endfunction

    task automatic put(input logic [7:0] b, input bit acc);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        if (acc) exp_q.push_back(int'(b));
    endtask

    task automatic drop();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // scoreboard monitor
    initial begin
        logic [4*DIG-1:0] prev;
        int meas = 0;
        int hcnt = 0;
        int want = 0;
        prev = {DIG{4'hE}};
        forever begin
            @(negedge clk);
            if (!rst && hist !== prev) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R3 unexpected history shift", longint'(hist), longint'(prev));
                end else begin
                    int n;
                    n = exp_q.pop_front();
                    model_hist = {model_hist[4*DIG-5:0], 4'(n)};
                    chk(hist == model_hist, "R6/R5 history", longint'(hist), longint'(model_hist));
                    want = exp_half(n);
                    meas = 1;
                    if (gap_on && have_last)
                        chk(cyc - last_t == SLOT + 2, "R2 slot spacing", cyc - last_t, SLOT + 2);
                    last_t = cyc;
                    have_last = 1;
                end
                prev = hist;
            end else if (meas == 1) begin
                if (buz) begin meas = 2; hcnt = 1; end
            end else if (meas == 2) begin
                if (buz) hcnt++;
                else begin
                    chk(hcnt == want, "R1 half period", hcnt, want);
                    meas = 0;
                end
            end
        end
    end

    initial begin
        wait (cyc >= LIMIT_CYC);
        bad++;
        total++;
        $display("FAIL watchdog R2 actual=%0d expected<%0d", cyc, LIMIT_CYC);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7 reset state
        chk(hist == {DIG{4'hE}}, "R7 history blank", longint'(hist), longint'({DIG{4'hE}}));
        chk(level == 0, "R7 level", level, 0);
        chk(!buz && !busy, "R7 buzzer/busy low", {buz, busy}, 0);

        // single note, R1 and R6
        put(8'd3, 1); drop();
        wait_idle();
        chk(exp_q.size() == 0, "R5 single note played", exp_q.size(), 0);

        // R9 bytes queued while a note plays
        put(8'd5, 1); drop();
        repeat (50) @(negedge clk);
        chk(busy == 1'b1, "R9 busy while playing", busy, 1);
        put(8'd2, 1); put(8'd7, 1); drop();
        chk(level == 2, "R9 queued during play", level, 2);
        wait_idle();
        chk(!buz && !busy, "R7 idle after drain", {buz, busy}, 0);

        // R3 out-of-range bytes
        put(8'd0, 0); put(8'd9, 0); put(8'h81, 0); drop();
        repeat (SLOT + 10) @(negedge clk);
        chk(level == 0, "R3 level unchanged", level, 0);
        chk(hist == model_hist, "R3 history unchanged", longint'(hist), longint'(model_hist));
        chk(!buz && !busy, "R3 buzzer/busy quiet", {buz, busy}, 0);

        // R4 / R8 overflow burst from idle, R2 spacing
        gap_on = 1; have_last = 0;
        for (int k = 1; k <= 110; k++) begin
            @(negedge clk);
            if (k == 3) chk(level == 1, "R8 write+read keeps level", level, 1);
            in_valid = 1'b1;
            in_byte  = 8'((k % 8) + 1);
            if (k <= 101) exp_q.push_back((k % 8) + 1);
        end
        drop();
        chk(level == LIMIT, "R4 level capped", level, LIMIT);
        wait_idle();
        gap_on = 0;
        chk(exp_q.size() == 0, "R5 all accepted notes played in order", exp_q.size(), 0);
        chk(!buz && level == 0, "R7 quiet at end", {buz, level}, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule